// File: doc/BRIEF.md
# Stride Reference Prediction Table

This block watches the stream of load and store accesses leaving a processor core and learns, per memory instruction, whether that instruction walks through memory with a constant step. Each access presents the instruction address (PC) and the effective data address. The block keeps a direct-mapped table indexed by low PC bits. Each entry records an instruction tag, the last data address seen, a learned stride and a four-state confidence machine.

On every access the entry is looked up. A miss allocates the entry afresh. A hit computes the new step as the current address minus the recorded one, compares it with the stored stride and advances the confidence machine. When that instruction's step has repeated and the entry lands in the steady state, the block raises a one-cycle prefetch request whose address is the current address plus the stride. Sending that request into the memory hierarchy is left to the surrounding logic.

Top module: `stride_rpt`

## Requirements
- R1: After reset `pf_valid` and `pf_addr` are 0 and every entry is empty, so the first access from any PC only allocates and gives no prefetch.
- R2: An access whose entry is empty or holds a different tag allocates the entry with the access tag, records the address, sets the stride to 0 and the state to INIT, and gives no prefetch.
- R3: On a hit the step is `acc_addr - previous address` modulo 2^ADDR_W, and the recorded address becomes `acc_addr` on every hit; a "match" means the step equals the stored stride.
- R4: An INIT entry moves to STEADY on a match; otherwise it moves to TRANSIENT and stores the new step as its stride.
- R5: A TRANSIENT entry moves to STEADY on a match; otherwise it moves to NO-PREDICTION and stores the new step.
- R6: A STEADY entry stays STEADY on a match; on a mismatch it falls to INIT, keeps its old stride and gives no prefetch.
- R7: A NO-PREDICTION entry moves to TRANSIENT on a match and gives no prefetch; on a mismatch it stays and stores the new step.
- R8: A prefetch is raised only for a hit that matches and whose resulting state is STEADY. It appears as `pf_valid` high for exactly one cycle, in the cycle after the access is sampled, with `pf_addr = acc_addr + stride` modulo 2^ADDR_W, so negative strides wrap.
- R9: The table holds 2^IDX_W entries (64 by default). The index is `acc_pc[PC_SKIP+IDX_W-1:PC_SKIP]` (bits 7:2 by default) and the tag is the PC bits above that. Two PCs with the same index but different tags evict each other.
- R10: An instruction that touches the same address twice in a row reaches STEADY with stride 0 and prefetches that same address.
- R11: A cycle with `acc_valid` low gives no prefetch and leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_pc | input | PC_W | Instruction address of the load or store |
| acc_addr | input | ADDR_W | Effective data address of the access |
| pf_valid | output | 1 | Prefetch request, one-cycle pulse |
| pf_addr | output | ADDR_W | Predicted address, meaningful when `pf_valid` is high |

## Verification
The assertions take for granted that every presented PC is word aligned (the PC_SKIP low bits are zero), since those bits take no part in indexing or tagging. They also take for granted that `acc_pc` and `acc_addr` are known whenever `acc_valid` is high. The stimulus uses only aligned PCs and drives every input at the falling edge, away from the sampling edge. Several streams are interleaved on distinct indices, and one deliberately aliased PC is used, so that each state transition, the wrap of a negative stride and eviction by a conflicting tag are all reached.

// File: rtl/stride_rpt_pkg.sv
package stride_rpt_pkg;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } rpt_state_e;

  // Confidence machine: where an entry goes after a hit.
  function automatic rpt_state_e advance_state(input rpt_state_e cur, input logic same_step);
    rpt_state_e nxt;
    unique case (cur)
      ST_INIT:   nxt = same_step ? ST_STEADY : ST_TRANS;
      ST_TRANS:  nxt = same_step ? ST_STEADY : ST_NOPRED;
      ST_STEADY: nxt = same_step ? ST_STEADY : ST_INIT;
      default:   nxt = same_step ? ST_TRANS  : ST_NOPRED;
    endcase
    return nxt;
  endfunction

  // Whether the learned stride is replaced by the fresh step.
  function automatic logic takes_new_step(input rpt_state_e cur, input logic same_step);
    return !same_step && (cur != ST_STEADY);
  endfunction

endpackage

// File: rtl/stride_rpt_index.sv
module stride_rpt_index #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int PC_SKIP = 2,
  parameter int TAG_W   = PC_W - IDX_W - PC_SKIP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);

  assign idx = pc[PC_SKIP +: IDX_W];
  assign tag = pc[PC_W-1 -: TAG_W];

  generate
    if (PC_SKIP > 0) begin : g_align
      // R9: the skipped low PC bits are expected to be zero.
      assert_pc_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (pc[PC_SKIP-1:0] == '0));
    end else begin : g_noalign
      assert_pc_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> !$isunknown(pc));
    end
  endgenerate

endmodule

// File: rtl/stride_rpt_store.sv
module stride_rpt_store
  import stride_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  parameter int DEPTH  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_prev,
  output logic [ADDR_W-1:0] rd_stride,
  output rpt_state_e        rd_state,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_prev,
  input  logic [ADDR_W-1:0] wr_stride,
  input  rpt_state_e        wr_state
);

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q    [DEPTH];
  logic [ADDR_W-1:0] prev_q   [DEPTH];
  logic [ADDR_W-1:0] stride_q [DEPTH];
  rpt_state_e        state_q  [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic sel;
      assign sel = wr_en && (idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q[e]  <= 1'b0;
          tag_q[e]    <= '0;
          prev_q[e]   <= '0;
          stride_q[e] <= '0;
          state_q[e]  <= ST_INIT;
        end else if (sel) begin
          valid_q[e]  <= 1'b1;
          tag_q[e]    <= wr_tag;
          prev_q[e]   <= wr_prev;
          stride_q[e] <= wr_stride;
          state_q[e]  <= wr_state;
        end
      end
    end
  endgenerate

  assign rd_valid  = valid_q[idx];
  assign rd_tag    = tag_q[idx];
  assign rd_prev   = prev_q[idx];
  assign rd_stride = stride_q[idx];
  assign rd_state  = state_q[idx];

  // R2: a written entry holds exactly what was offered on the next cycle.
  assert_entry_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(idx)] && tag_q[$past(idx)] == $past(wr_tag)
               && state_q[$past(idx)] == $past(wr_state)));

  // R3: the recorded address follows the access.
  assert_prev_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (prev_q[$past(idx)] == $past(wr_prev)));

  // R11: without a write the selected entry keeps its contents.
  assert_entry_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (prev_q[$past(idx)] == $past(rd_prev)
                && stride_q[$past(idx)] == $past(rd_stride)
                && valid_q[$past(idx)] == $past(rd_valid)));

endmodule

// File: rtl/stride_rpt_update.sv
module stride_rpt_update
  import stride_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [TAG_W-1:0]  acc_tag,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [ADDR_W-1:0] rd_prev,
  input  logic [ADDR_W-1:0] rd_stride,
  input  rpt_state_e        rd_state,
  output logic              hit,
  output logic              step_match,
  output logic              wr_en,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [ADDR_W-1:0] wr_prev,
  output logic [ADDR_W-1:0] wr_stride,
  output rpt_state_e        wr_state,
  output logic              pf_fire,
  output logic [ADDR_W-1:0] pf_target
);

  // Step between two addresses, modulo the address width.
  function automatic logic [ADDR_W-1:0] step_between(input logic [ADDR_W-1:0] now_a,
                                                    input logic [ADDR_W-1:0] then_a);
    return now_a - then_a;
  endfunction

  // Next address along a stream.
  function automatic logic [ADDR_W-1:0] project_ahead(input logic [ADDR_W-1:0] base,
                                                     input logic [ADDR_W-1:0] step);
    return base + step;
  endfunction

  logic [ADDR_W-1:0] fresh_step;

  assign hit        = acc_valid && rd_valid && (rd_tag == acc_tag);
  assign fresh_step = step_between(acc_addr, rd_prev);
  assign step_match = (fresh_step == rd_stride);

  assign wr_en   = acc_valid;
  assign wr_tag  = acc_tag;
  assign wr_prev = acc_addr;

  always_comb begin
    if (hit) begin
      wr_state  = advance_state(rd_state, step_match);
      wr_stride = takes_new_step(rd_state, step_match) ? fresh_step : rd_stride;
    end else begin
      wr_state  = ST_INIT;
      wr_stride = '0;
    end
  end

  assign pf_fire   = hit && step_match && (wr_state == ST_STEADY);
  assign pf_target = project_ahead(acc_addr, rd_stride);

  // R2: an allocation never produces a request.
  assert_miss_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hit) |-> !pf_fire);

  // R7: an entry without a prediction never requests.
  assert_nopred_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rd_state == ST_NOPRED) |-> !pf_fire);

  // R6: a broken steady stream keeps its stride.
  assert_steady_keeps_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rd_state == ST_STEADY && !step_match) |-> (wr_stride == rd_stride && wr_state == ST_INIT));

  // R4 R5: a first mismatch from INIT or TRANSIENT stores the fresh step.
  assert_learn_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !step_match && (rd_state == ST_INIT || rd_state == ST_TRANS)) |-> (wr_stride == fresh_step));

endmodule

// File: rtl/stride_rpt.sv
module stride_rpt
  import stride_rpt_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int PC_SKIP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  localparam int TAG_W = PC_W - IDX_W - PC_SKIP;
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_prev;
  logic [ADDR_W-1:0] rd_stride;
  rpt_state_e        rd_state;
  logic              hit;
  logic              step_match;
  logic              wr_en;
  logic [TAG_W-1:0]  wr_tag;
  logic [ADDR_W-1:0] wr_prev;
  logic [ADDR_W-1:0] wr_stride;
  rpt_state_e        wr_state;
  logic              pf_fire;
  logic [ADDR_W-1:0] pf_target;

  stride_rpt_index #(
    .PC_W(PC_W), .IDX_W(IDX_W), .PC_SKIP(PC_SKIP), .TAG_W(TAG_W)
  ) u_index (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .pc(acc_pc), .idx(lk_idx), .tag(lk_tag)
  );

  stride_rpt_store #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DEPTH(DEPTH)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .idx(lk_idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_prev(rd_prev),
    .rd_stride(rd_stride), .rd_state(rd_state),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_prev(wr_prev),
    .wr_stride(wr_stride), .wr_state(wr_state)
  );

  stride_rpt_update #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W)
  ) u_update (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_tag(lk_tag), .acc_addr(acc_addr),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_prev(rd_prev),
    .rd_stride(rd_stride), .rd_state(rd_state),
    .hit(hit), .step_match(step_match),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_prev(wr_prev),
    .wr_stride(wr_stride), .wr_state(wr_state),
    .pf_fire(pf_fire), .pf_target(pf_target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= pf_fire;
      if (pf_fire) pf_addr <= pf_target;
    end
  end

  // R8: a request always traces back to a confident matching hit.
  assert_pf_needs_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> ($past(hit) && $past(step_match) && $past(wr_state) == ST_STEADY));

  // R11: an idle cycle is followed by no request.
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !pf_valid);

  // R6: a broken steady stream is followed by no request.
  assert_break_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rd_state == ST_STEADY && !step_match) |=> !pf_valid);

  // R8: the address is only updated along with a request.
  assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid |-> $stable(pf_addr) || $past(!rst_n));

endmodule

// File: tb/stride_rpt_test.sv
`timescale 1ns/1ps
module stride_rpt_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  stride_rpt uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_pc(acc_pc), .acc_addr(acc_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] addr;
    logic        go;
    logic        pf;
    logic [31:0] tgt;
  } vec_t;

  localparam int NVEC = 28;
  localparam vec_t VECS [NVEC] = '{
    // stream A (index 4), stride 4: R2 R4 R5 R8
    '{32'h1000_0010, 32'h0000_5000, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0010, 32'h0000_5004, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0010, 32'h0000_5008, 1'b1, 1'b1, 32'h0000_500C},
    '{32'h1000_0010, 32'h0000_500C, 1'b1, 1'b1, 32'h0000_5010},
    // stream B (index 8), same address: R10, interleaved with A
    '{32'h1000_0020, 32'h0000_9000, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0010, 32'h0000_5010, 1'b1, 1'b1, 32'h0000_5014},
    '{32'h1000_0020, 32'h0000_9000, 1'b1, 1'b1, 32'h0000_9000},
    // idle: R11
    '{32'h1000_0010, 32'h0000_0000, 1'b0, 1'b0, 32'h0},
    // A breaks: R6 (stride 4 kept, back in at once)
    '{32'h1000_0010, 32'h0000_6000, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0010, 32'h0000_6004, 1'b1, 1'b1, 32'h0000_6008},
    // stream C (index 12): transient to no-prediction and back, R5 R7
    '{32'h1000_0030, 32'h0000_1000, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0030, 32'h0000_1010, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0030, 32'h0000_1018, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0030, 32'h0000_1020, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0030, 32'h0000_1028, 1'b1, 1'b1, 32'h0000_1030},
    // stream D (index 16): no-prediction mismatch relearns, R7
    '{32'h1000_0040, 32'h0000_0100, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0040, 32'h0000_0110, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0040, 32'h0000_0118, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0040, 32'h0000_011C, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0040, 32'h0000_0120, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0040, 32'h0000_0124, 1'b1, 1'b1, 32'h0000_0128},
    // stream E (index 20): negative stride wraps, R3 R8
    '{32'h1000_0050, 32'h0000_0008, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0050, 32'h0000_0004, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0050, 32'h0000_0000, 1'b1, 1'b1, 32'hFFFF_FFFC},
    // alias of A on index 4 evicts it: R9
    '{32'h1000_0110, 32'h0000_7000, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0010, 32'h0000_6008, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0010, 32'h0000_600C, 1'b1, 1'b0, 32'h0},
    '{32'h1000_0010, 32'h0000_6010, 1'b1, 1'b1, 32'h0000_6014}
  };

  task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Drive at the falling edge, sample one falling edge later.
  task automatic step(input logic go, input logic [31:0] pc, input logic [31:0] addr);
    acc_valid = go;
    acc_pc    = pc;
    acc_addr  = addr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_pf(input logic epf, input logic [31:0] eaddr, input string what);
    check(pf_valid == epf, what, {31'b0, pf_valid}, {31'b0, epf});
    if (epf) check(pf_addr == eaddr, what, pf_addr, eaddr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_pf(1'b0, 32'h0, "R1 pf_valid in reset");
    check(pf_addr == 32'h0, "R1 pf_addr in reset", pf_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_pf(1'b0, 32'h0, "R1 pf_valid after reset");

    // Vector walk covering R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].go, VECS[i].pc, VECS[i].addr);
      expect_pf(VECS[i].pf, VECS[i].tgt, $sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)", i));
    end

    // R8: pulse lasts one cycle
    step(1'b0, 32'h0, 32'h0);
    expect_pf(1'b0, 32'h0, "R8 pulse width");
    check(pf_addr == 32'h0000_6014, "R8 address held", pf_addr, 32'h0000_6014);

    // R11: idle cycles leave the steady stream A intact
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 32'h1000_0010, 32'h0000_DEAD);
      expect_pf(1'b0, 32'h0, "R11 idle");
    end
    step(1'b1, 32'h1000_0010, 32'h0000_6014);
    expect_pf(1'b1, 32'h0000_6018, "R11 stream survives idle");

    // R1: a reset empties the table
    rst_n = 1'b0;
    @(negedge clk);
    expect_pf(1'b0, 32'h0, "R1 reset mid-run");
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b1, 32'h1000_0010, 32'h0000_6018);
    expect_pf(1'b0, 32'h0, "R1 table emptied");
    step(1'b1, 32'h1000_0010, 32'h0000_601C);
    expect_pf(1'b0, 32'h0, "R4 transient after reset");
    step(1'b1, 32'h1000_0010, 32'h0000_6020);
    expect_pf(1'b1, 32'h0000_6024, "R8 steady after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule